// File: doc/BRIEF.md
# Checksummed Tape Block Loader

This block is a hardware bootstrap loader. It accepts a stream of 6-bit tape frames, packs each group of six frames into a 36-bit word, and parses the words as a sequence of blocks. Each block opens with a control word. Its sign bit is set, its upper half holds the negated word count and its lower half holds the load address minus one. The data words follow and are written to memory one by one. A checksum word closes the block.

The running checksum starts from the control word itself and accumulates every data word, modulo 2^36. A block whose checksum word differs from the running sum halts the loader with an error flag. The operator can then rewind the tape and pulse `restart` to read the block again. A word with a clear sign bit in the header position ends the tape. The loader latches it as the start-of-program word, reports its lower half as the entry address and stops.

Frames enter through a valid/ready handshake. A frame is taken in any cycle where `frame_valid` and `frame_ready` are both high. The source must hold `frame_data` steady while `frame_valid` is high and `frame_ready` is low. `frame_ready` goes low once a complete word is buffered and the parser is not taking it, for example in the halted or finished state. The memory side has no back-pressure: the memory must accept every write strobe.

Top module: `tape_loader`

## Requirements
- R1: Six consecutive accepted frames form one 36-bit word, most significant first: the first frame fills bits 35:30 and the sixth fills bits 5:0.
- R2: A word is parsed only after all six of its frames are accepted. While a completed word waits unconsumed, `frame_ready` is low, so idle gaps between frames neither lose nor duplicate frames.
- R3: A header word with bit 35 set is a control word. For each data word, both 18-bit halves of the control word are incremented, and the word is written to the new lower half, which wraps from 0x3FFFF to 0x00000.
- R4: Each data word produces exactly one `mem_we` pulse, with `mem_addr` and `mem_wdata` valid in the same cycle. A block with count N produces exactly N writes, and the checksum word follows after the upper half reaches zero.
- R5: The checksum is seeded with the full 36-bit control word, and every data word is added to it with the carry out of bit 35 discarded. When the checksum word equals the sum, the loader returns to the header state and `halted_err` stays low.
- R6: When the checksum word differs from the sum, `halted_err` rises, the loader halts, and it performs no further writes.
- R7: While the loader is halted, `restart` clears `halted_err`, discards any partly assembled word and returns the loader to the header state, so that the block can be read again.
- R8: A header word with bit 35 clear sets `start_done`, latches the word on `start_word` and its bits 17:0 on `start_addr`, and performs no write. Afterwards the loader takes no more words, so `frame_ready` falls once another word has been assembled.
- R9: After reset `frame_ready` is 1 and `mem_we`, `halted_err` and `start_done` are 0.
- R10: `restart` has no effect outside the halted state: a pulse in the header state leaves `halted_err` low, and the next block loads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | A tape frame is offered |
| frame_data | input | 6 | Tape frame value |
| frame_ready | output | 1 | The loader accepts a frame this cycle |
| restart | input | 1 | Operator restart, acted on only while halted |
| mem_we | output | 1 | Memory write strobe, one per data word |
| mem_addr | output | 18 | Memory write address |
| mem_wdata | output | 36 | Memory write data |
| halted_err | output | 1 | Halted on a checksum mismatch |
| start_done | output | 1 | Start-of-program word received |
| start_word | output | 36 | Latched start-of-program word |
| start_addr | output | 18 | Lower half of the start-of-program word |

## Verification
The hardest situation to reach is a re-read after a checksum failure that happens while stray frames are already in the packer. This is the state in which a missing flush shifts every later word out of frame alignment. The stimulus sends a block with a deliberately wrong checksum word and waits for the halt. It then feeds two loose frames, pulses `restart` and sends the same block again with the correct checksum. The scoreboard expects the rewritten words at their proper addresses. The address wrap and the carry out of bit 35 are reached with a block loaded at the top of the address space, using all-ones data.

// File: rtl/tl_pkg.sv
package tl_pkg;
  typedef enum logic [2:0] {
    ST_HDR  = 3'd0,
    ST_DATA = 3'd1,
    ST_CSUM = 3'd2,
    ST_HALT = 3'd3,
    ST_DONE = 3'd4
  } ld_state_e;
endpackage

// File: rtl/tl_frame_packer.sv
module tl_frame_packer #(
  parameter int FW = 6,
  parameter int NF = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            frame_valid,
  input  logic [FW-1:0]   frame_data,
  output logic            frame_ready,
  output logic            word_valid,
  output logic [FW*NF-1:0] word_data,
  input  logic            word_ready
);
  localparam int WW = FW * NF;
  localparam int CW = (NF > 1) ? $clog2(NF) : 1;
  localparam logic [CW-1:0] LAST = CW'(NF - 1);

  logic [WW-1:0] shreg;
  logic [CW-1:0] cnt;
  logic          full;
  logic          take;

  assign frame_ready = !full;
  assign take        = frame_valid && frame_ready;
  assign word_valid  = full;
  assign word_data   = shreg;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      shreg <= '0;
      cnt   <= '0;
      full  <= 1'b0;
    end else begin
      if (take) begin
        shreg <= {shreg[WW-FW-1:0], frame_data};
        if (cnt == LAST) begin
          cnt  <= '0;
          full <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (full && word_ready) full <= 1'b0;
    end
  end

  // R2: a waiting word holds its value until the parser takes it
  p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));
endmodule

// File: rtl/tl_sum_acc.sv
module tl_sum_acc #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_en,
  input  logic [W-1:0] seed,
  input  logic         add_en,
  input  logic [W-1:0] addend,
  output logic [W-1:0] sum
);
  always_ff @(posedge clk) begin
    if (!rst_n)       sum <= '0;
    else if (seed_en) sum <= seed;
    else if (add_en)  sum <= sum + addend;
  end
endmodule

// File: rtl/tl_block_parser.sv
module tl_block_parser
  import tl_pkg::*;
#(
  parameter int W = 36
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           word_valid,
  input  logic [W-1:0]   word_data,
  output logic           word_ready,
  input  logic           restart,
  output logic           flush,
  output logic           seed_en,
  output logic           add_en,
  input  logic [W-1:0]   sum_val,
  output logic           mem_we,
  output logic [W/2-1:0] mem_addr,
  output logic [W-1:0]   mem_wdata,
  output logic           halted_err,
  output logic           start_done,
  output logic [W-1:0]   start_word,
  output logic [W/2-1:0] start_addr
);
  localparam int H = W / 2;

  ld_state_e    state;
  logic [W-1:0] ctl;
  logic [W-1:0] ctl_nxt;
  logic         take;

  assign word_ready = (state == ST_HDR) || (state == ST_DATA) || (state == ST_CSUM);
  assign take       = word_valid && word_ready;
  assign ctl_nxt    = {ctl[W-1:H] + 1'b1, ctl[H-1:0] + 1'b1};
  assign seed_en    = take && (state == ST_HDR) && word_data[W-1];
  assign add_en     = take && (state == ST_DATA);
  assign flush      = (state == ST_HALT) && restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_HDR;
      ctl        <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      halted_err <= 1'b0;
      start_done <= 1'b0;
      start_word <= '0;
      start_addr <= '0;
    end else begin
      mem_we <= 1'b0;
      case (state)
        ST_HDR: if (take) begin
          if (word_data[W-1]) begin
            ctl   <= word_data;
            state <= ST_DATA;
          end else begin
            start_word <= word_data;
            start_addr <= word_data[H-1:0];
            start_done <= 1'b1;
            state      <= ST_DONE;
          end
        end
        ST_DATA: if (take) begin
          ctl       <= ctl_nxt;
          mem_we    <= 1'b1;
          mem_addr  <= ctl_nxt[H-1:0];
          mem_wdata <= word_data;
          if (!ctl_nxt[W-1]) state <= ST_CSUM;
        end
        ST_CSUM: if (take) begin
          if (word_data == sum_val) begin
            state <= ST_HDR;
          end else begin
            halted_err <= 1'b1;
            state      <= ST_HALT;
          end
        end
        ST_HALT: if (restart) begin
          halted_err <= 1'b0;
          state      <= ST_HDR;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  // R4: writes come only from data-word consumption
  p_write_from_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(state) == ST_DATA));
  // R6: an error only follows a checksum comparison
  p_err_from_csum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted_err) |-> ($past(state) == ST_CSUM));
  // R6: no writes while halted
  p_no_write_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_err && $past(halted_err)) |-> !mem_we);
  // R7: error holds until restart
  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_err && !restart) |=> halted_err);
  // R8: start word is sticky
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |=> (start_done && $stable(start_word) && !mem_we));
endmodule

// File: rtl/tape_loader.sv
module tape_loader #(
  parameter int FRAME_W = 6,
  parameter int FRAMES  = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_valid,
  input  logic [FRAME_W-1:0]            frame_data,
  output logic                          frame_ready,
  input  logic                          restart,
  output logic                          mem_we,
  output logic [FRAME_W*FRAMES/2-1:0]   mem_addr,
  output logic [FRAME_W*FRAMES-1:0]     mem_wdata,
  output logic                          halted_err,
  output logic                          start_done,
  output logic [FRAME_W*FRAMES-1:0]     start_word,
  output logic [FRAME_W*FRAMES/2-1:0]   start_addr
);
  localparam int WW = FRAME_W * FRAMES;

  logic          w_valid, w_ready, flush, seed_en, add_en;
  logic [WW-1:0] w_data, sum_val;

  tl_frame_packer #(.FW(FRAME_W), .NF(FRAMES)) u_pack (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .frame_valid(frame_valid), .frame_data(frame_data), .frame_ready(frame_ready),
    .word_valid(w_valid), .word_data(w_data), .word_ready(w_ready)
  );

  tl_sum_acc #(.W(WW)) u_sum (
    .clk(clk), .rst_n(rst_n), .seed_en(seed_en), .seed(w_data),
    .add_en(add_en), .addend(w_data), .sum(sum_val)
  );

  tl_block_parser #(.W(WW)) u_parse (
    .clk(clk), .rst_n(rst_n),
    .word_valid(w_valid), .word_data(w_data), .word_ready(w_ready),
    .restart(restart), .flush(flush), .seed_en(seed_en), .add_en(add_en),
    .sum_val(sum_val), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .halted_err(halted_err), .start_done(start_done),
    .start_word(start_word), .start_addr(start_addr)
  );
endmodule

// File: tb/tb_tape_loader.sv
module tb_tape_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0;
  logic [5:0]  frame_data = '0;
  logic        frame_ready;
  logic        restart = 1'b0;
  logic        mem_we;
  logic [17:0] mem_addr;
  logic [35:0] mem_wdata;
  logic        halted_err, start_done;
  logic [35:0] start_word;
  logic [17:0] start_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic [53:0] exp_q[$];

  always #5 clk = ~clk;

  tape_loader dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
    .frame_ready(frame_ready), .restart(restart), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .halted_err(halted_err),
    .start_done(start_done), .start_word(start_word), .start_addr(start_addr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design issues them (R1, R3, R4)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected write", {10'd0, mem_addr, mem_wdata}, 64'hDEAD);
      end else begin
        logic [53:0] e;
        e = exp_q.pop_front();
        check("R1 R3 write addr/data", {10'd0, mem_addr, mem_wdata}, {10'd0, e});
      end
    end
  end

  task automatic send_frame(input logic [5:0] f, input int gap);
    @(negedge clk);
    frame_valid = 1'b1;
    frame_data  = f;
    while (!frame_ready) @(negedge clk);
    @(negedge clk);
    frame_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_word(input logic [35:0] w, input int gap);
    for (int k = 0; k < 6; k++) send_frame(w[35-6*k -: 6], gap);
  endtask

  task automatic send_block(input logic [17:0] base_m1, input int n,
                            input logic [35:0] d [4], input bit bad, input int gap);
    logic [35:0] ctl, sum;
    logic [17:0] a;
    logic [17:0] neg;
    neg = 18'd0 - 18'(n);
    ctl = {neg, base_m1};
    sum = ctl;
    a   = base_m1;
    for (int i = 0; i < n; i++) begin
      a   = a + 18'd1;
      exp_q.push_back({a, d[i]});
      sum = sum + d[i];
    end
    send_word(ctl, gap);
    for (int i = 0; i < n; i++) send_word(d[i], gap);
    send_word(bad ? (sum ^ 36'd1) : sum, gap);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [35:0] d [4];
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 frame_ready", 64'(frame_ready), 64'd1);
    check("R9 mem_we", 64'(mem_we), 64'd0);
    check("R9 halted_err", 64'(halted_err), 64'd0);
    check("R9 start_done", 64'(start_done), 64'd0);
    rst_n = 1'b1;

    // block A: three words, MSB-first frame check via data patterns (R1, R3)
    d = '{36'h123456789, 36'hFEDCBA987, 36'h0A5A5A5A5, 36'h0};
    send_block(18'o77, 3, d, 1'b0, 0);
    check("R5 good block no error", 64'(halted_err), 64'd0);
    check("R4 all writes seen A", 64'(exp_q.size()), 64'd0);

    // block B: address wrap and checksum carry out of bit 35 (R3, R5)
    d = '{36'hFFFFFFFFF, 36'hFFFFFFFFF, 36'h800000001, 36'h0};
    send_block(18'h3FFFE, 3, d, 1'b0, 0);
    check("R5 carry discarded no error", 64'(halted_err), 64'd0);
    check("R4 all writes seen B", 64'(exp_q.size()), 64'd0);

    // R10: restart in header state is ignored
    @(negedge clk); restart = 1'b1; @(negedge clk); restart = 1'b0;
    check("R10 err stays low", 64'(halted_err), 64'd0);
    check("R10 ready stays", 64'(frame_ready), 64'd1);

    // block C with gaps between frames (R2)
    d = '{36'h00000003F, 36'hFC0000000, 36'h0, 36'h0};
    send_block(18'o1000, 2, d, 1'b0, 3);
    check("R2 gapped block no error", 64'(halted_err), 64'd0);
    check("R4 all writes seen C", 64'(exp_q.size()), 64'd0);

    // block D with bad checksum (R6)
    d = '{36'h111111111, 36'h222222222, 36'h0, 36'h0};
    send_block(18'o2000, 2, d, 1'b1, 0);
    check("R6 error raised", 64'(halted_err), 64'd1);
    check("R4 all writes seen D", 64'(exp_q.size()), 64'd0);
    // stray frames while halted, then restart must discard them (R7)
    send_frame(6'o52, 0);
    send_frame(6'o25, 0);
    repeat (4) @(negedge clk);
    check("R6 still halted", 64'(halted_err), 64'd1);
    restart = 1'b1; @(negedge clk); restart = 1'b0;
    @(negedge clk);
    check("R7 error cleared", 64'(halted_err), 64'd0);
    send_block(18'o2000, 2, d, 1'b0, 1);
    check("R7 re-read no error", 64'(halted_err), 64'd0);
    check("R7 re-read writes seen", 64'(exp_q.size()), 64'd0);

    // start word (R8)
    send_word(36'h2C0000042, 0);
    repeat (3) @(negedge clk);
    check("R8 start_done", 64'(start_done), 64'd1);
    check("R8 start_word", 64'(start_word), 64'h2C0000042);
    check("R8 start_addr", 64'(start_addr), 64'h42);
    send_word(36'h812345678, 0);
    repeat (3) @(negedge clk);
    check("R8 ready low after done", 64'(frame_ready), 64'd0);
    check("R8 no extra writes", 64'(exp_q.size()), 64'd0);
    check("R8 word unchanged", 64'(start_word), 64'h2C0000042);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule